// File: doc/BRIEF.md
# Transactional Commit/Discard FIFO

A single-clock FIFO whose two sides both work in batches. The producer pushes words speculatively and then either publishes the whole batch to the consumer with a commit pulse or throws it away with a discard pulse. The consumer reads speculatively too. Storage is released only when it commits what it has read, and it can discard to rewind and read the same words again.

A typical use is a packet buffer on a link that can abort or retry. A frame that fails its check is dropped on the producer side. A frame whose delivery is not acknowledged is replayed on the consumer side. Each side keeps two pointers: a committed pointer and a speculative one. Visibility and free space are computed from the pointer of the opposite side that is safe to use.

Top module: `txn_fifo`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0 and `free_count` equals DEPTH.
- R2: An accepted write lowers `free_count` by one, seen the cycle after the write. The word stays invisible (`empty` unchanged) until `wr_commit` is pulsed. A commit pulse in the same cycle as a write publishes that write too.
- R3: `rd_data` always shows the oldest visible word that has not yet been read, without a read cycle first. Each `rd_en` cycle that is accepted moves to the next word. Reading the last visible word sets `empty`, but `free_count` does not change.
- R4: `full` is 1 when DEPTH words are stored and not yet released, whether or not they are committed. It can therefore be 1 together with `empty`. A write while `full` is ignored and does not change `free_count`, the flags or the stored data.
- R5: `rd_commit` releases every word read since the previous read commit. `free_count` rises by that number the next cycle and `full` clears.
- R6: `wr_discard` drops all writes since the last write commit, restores their space, and the dropped words never reach `rd_data`.
- R7: `rd_discard` rewinds reading to the last read commit. `empty` clears if words were pending, and the same words come out again in the same order.
- R8: A read while `empty` is 1 is ignored. The read position, `empty` and `free_count` are unchanged.
- R9: When commit and discard are pulsed together on one side, the discard wins. A write or read in that same cycle on that side is dropped.
- R10: Word order is preserved across many wrap-arounds of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | WIDTH | Word to store |
| wr_en | input | 1 | Store `wr_data` this cycle (ignored while full) |
| wr_commit | input | 1 | Publish all pending writes to the reader |
| wr_discard | input | 1 | Drop all pending writes |
| rd_data | output | WIDTH | Word at the speculative read position |
| rd_en | input | 1 | Consume `rd_data` this cycle (ignored while empty) |
| rd_commit | input | 1 | Release storage of all pending reads |
| rd_discard | input | 1 | Rewind reads to the last read commit |
| empty | output | 1 | No committed word left to read |
| full | output | 1 | No free storage left for writes |
| free_count | output | $clog2(DEPTH)+1 | Number of words that can still be written |

## Verification
The assertions check the cycle-level invariants on every cycle. Occupancy never exceeds DEPTH. A refused write keeps the FIFO full, and an empty FIFO stays empty without a write commit or read rewind. Free space grows only through a read commit or a write discard. A discard realigns a side's pointers and leaves its committed pointer alone even when a commit arrives with it. Whether the data is correct can only be shown by the bench scenarios, because a scoreboard compares every consumed word. These scenarios are replay after a rewind, the absence of discarded words, and order kept across wrap-around.

// File: rtl/txf_pkg.sv
// Package: shared definitions for the transactional FIFO.
// Holds the per-cycle action decoded by each pointer pair.
package txf_pkg;

    // What a pointer pair does on a given clock edge.
    typedef enum logic [1:0] {
        PA_HOLD     = 2'd0,  // nothing changes
        PA_ADVANCE  = 2'd1,  // speculative pointer steps by one
        PA_PUBLISH  = 2'd2,  // committed pointer catches up (incl. a same-cycle step)
        PA_ROLLBACK = 2'd3   // speculative pointer returns to the committed one
    } ptr_action_e;

endpackage

// File: rtl/txf_ptr_pair.sv
// Module: txf_ptr_pair
// Keeps one side's committed and speculative pointers.
// Assumes: the pointers are PW bits wide (address plus one wrap bit). The
// caller gates step_i with its own full/empty condition. A discard overrides
// a commit and also drops a step in the same cycle.
module txf_ptr_pair
    import txf_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          commit_i,
    input  logic          discard_i,
    output logic [PW-1:0] spec_o,
    output logic [PW-1:0] cmt_o
);

    ptr_action_e   action;
    logic [PW-1:0] spec_next;

    // Decide this cycle's action, with discard taking priority.
    always_comb begin
        spec_next = spec_o + PW'(step_i);
        if (discard_i)      action = PA_ROLLBACK;
        else if (commit_i)  action = PA_PUBLISH;
        else if (step_i)    action = PA_ADVANCE;
        else                action = PA_HOLD;
    end

    // Update both pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_o <= '0;
            cmt_o  <= '0;
        end else begin
            case (action)
                PA_ROLLBACK: spec_o <= cmt_o;
                PA_PUBLISH: begin
                    spec_o <= spec_next;
                    cmt_o  <= spec_next;
                end
                PA_ADVANCE:  spec_o <= spec_next;
                default:     ;
            endcase
        end
    end

    // R6 / R7: after a discard the speculative pointer sits on the committed one.
    p_discard_realigns_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
        discard_i |=> (spec_o == cmt_o));

    // R9: a discard leaves the committed pointer untouched even with a commit.
    p_discard_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_i && commit_i) |=> $stable(cmt_o));

    // R2 / R5: the committed pointer moves only on a commit pulse.
    p_cmt_moves_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(cmt_o));

endmodule

// File: rtl/txf_ram.sv
// Module: txf_ram
// Storage array with a synchronous write port and an asynchronous read port.
// The read port gives first-word-fall-through behaviour.
// Assumes: the contents are not reset. The read side never looks at a slot
// before a write to it has been committed.
module txf_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word when enabled.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Present the addressed word without a clock.
    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/txn_fifo.sv
// Module: txn_fifo (top)
// Synchronous FIFO with commit/discard on both sides. Writes become visible
// only when committed. Storage is freed only when reads are committed.
// Assumes: DEPTH is a power of two. Single clock with synchronous active-low
// reset. Status outputs follow the registered pointers.
module txn_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    input  logic             wr_commit,
    input  logic             wr_discard,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_en,
    input  logic             rd_commit,
    input  logic             rd_discard,
    output logic             empty,
    output logic             full,
    output logic [PW-1:0]    free_count
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wr_spec, wr_cmt, rd_spec, rd_cmt;
    logic [PW-1:0] occupancy;
    logic          wr_step, rd_step, ram_we;

    // Flags: space is counted against released reads, data against committed writes.
    always_comb begin
        occupancy  = wr_spec - rd_cmt;
        full       = (occupancy == DEPTH_P);
        free_count = DEPTH_P - occupancy;
        empty      = (rd_spec == wr_cmt);
        wr_step    = wr_en && !full;
        rd_step    = rd_en && !empty;
        ram_we     = wr_step && !wr_discard;
    end

    txf_ptr_pair #(.PW(PW)) u_wr_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (wr_step),
        .commit_i  (wr_commit),
        .discard_i (wr_discard),
        .spec_o    (wr_spec),
        .cmt_o     (wr_cmt)
    );

    txf_ptr_pair #(.PW(PW)) u_rd_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (rd_step),
        .commit_i  (rd_commit),
        .discard_i (rd_discard),
        .spec_o    (rd_spec),
        .cmt_o     (rd_cmt)
    );

    txf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i (wr_spec[AW-1:0]),
        .wdata_i (wr_data),
        .raddr_i (rd_spec[AW-1:0]),
        .rdata_o (rd_data)
    );

    // R4: held words never exceed the storage depth.
    p_occupancy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_spec - rd_cmt) <= DEPTH_P);

    // R4: a refused write keeps the FIFO full unless space is released.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !wr_discard && !rd_commit) |=> full);

    // R8: an empty FIFO stays empty without a write commit or a read rewind.
    p_no_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_commit && !rd_discard) |=> empty);

    // R5 / R6: free space grows only through a read commit or a write discard.
    p_space_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_commit && !wr_discard) |=> (free_count <= $past(free_count)));

    // R2: an accepted write takes exactly one slot.
    p_write_takes_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !wr_discard && !rd_commit) |=>
        (free_count == $past(free_count) - PW'(1)));

endmodule

// File: tb/sim_txn_fifo.sv
// Bench for txn_fifo. A reference queue model gives the expected flags. Read
// tasks push expected words to a scoreboard, and a monitor pops and compares
// each word the design consumes.
module sim_txn_fifo;

    localparam int W  = 8;
    localparam int D  = 16;
    localparam int PW = $clog2(D) + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_en = 1'b0, wr_commit = 1'b0, wr_discard = 1'b0;
    logic         rd_en = 1'b0, rd_commit = 1'b0, rd_discard = 1'b0;
    logic [W-1:0] rd_data;
    logic         empty, full;
    logic [PW-1:0] free_count;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    logic [W-1:0] c_list[$];   // committed words not yet released
    logic [W-1:0] w_pend[$];   // uncommitted writes
    int           rpos = 0;    // speculative read index into c_list
    logic [W-1:0] sb_q[$];     // scoreboard of expected read words

    always #2 clk = ~clk;

    txn_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_en(wr_en), .wr_commit(wr_commit), .wr_discard(wr_discard),
        .rd_data(rd_data), .rd_en(rd_en), .rd_commit(rd_commit), .rd_discard(rd_discard),
        .empty(empty), .full(full), .free_count(free_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_space();
        return D - (c_list.size() + w_pend.size());
    endfunction

    task automatic chk_status(input string req);
        chk(req, "empty", int'(empty), int'(rpos == c_list.size()));
        chk(req, "full", int'(full), int'(m_space() == 0));
        chk(req, "free_count", int'(free_count), m_space());
    endtask

    // Monitor: compare each consumed word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_en && !rd_discard && !empty) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL %s rd_data: actual=%0d expected=<none>", cur_req, rd_data);
            end else begin
                logic [W-1:0] e;
                e = sb_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s rd_data: actual=%0d expected=%0d", cur_req, rd_data, e);
                end
            end
        end
    end

    // Driver: one clock of stimulus, model updated from the requirements.
    task automatic op(input logic we, input logic [W-1:0] wd, input logic wc, input logic wx,
                      input logic re, input logic rc, input logic rx);
        bit m_full, m_empty;
        m_full  = (m_space() == 0);
        m_empty = (rpos == c_list.size());
        wr_en = we; wr_data = wd; wr_commit = wc; wr_discard = wx;
        rd_en = re; rd_commit = rc; rd_discard = rx;
        if (wx) w_pend.delete();
        else begin
            if (we && !m_full) w_pend.push_back(wd);
            if (wc) begin
                foreach (w_pend[i]) c_list.push_back(w_pend[i]);
                w_pend.delete();
            end
        end
        if (rx) rpos = 0;
        else begin
            if (re && !m_empty) begin
                sb_q.push_back(c_list[rpos]);
                rpos++;
            end
            if (rc) begin
                for (int i = 0; i < rpos; i++) void'(c_list.pop_front());
                rpos = 0;
            end
        end
        @(posedge clk); #1;
        wr_en = 0; wr_commit = 0; wr_discard = 0;
        rd_en = 0; rd_commit = 0; rd_discard = 0;
    endtask

    task automatic wr(input logic [W-1:0] d);  op(1, d, 0, 0, 0, 0, 0); endtask
    task automatic wcommit();                  op(0, 0, 1, 0, 0, 0, 0); endtask
    task automatic rd();                       op(0, 0, 0, 0, 1, 0, 0); endtask
    task automatic rcommit();                  op(0, 0, 0, 0, 0, 1, 0); endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "free_count", int'(free_count), D);

        // R2: write takes space, stays invisible until commit
        cur_req = "R2";
        wr(8'hAA);
        chk("R2", "free_count", int'(free_count), D - 1);
        chk("R2", "empty", int'(empty), 1);
        wcommit();
        chk("R2", "empty_after_commit", int'(empty), 0);

        // R3: read last visible word, space unchanged until commit
        cur_req = "R3";
        chk("R3", "fwft_data", int'(rd_data), 8'hAA);
        rd();
        chk_status("R3");
        chk("R3", "free_count", int'(free_count), D - 1);
        cur_req = "R5";
        rcommit();
        chk("R5", "free_count", int'(free_count), D);

        // R4: fill with uncommitted writes -> full and empty together
        cur_req = "R4";
        for (int i = 0; i < D; i++) wr(8'(i));
        chk("R4", "full", int'(full), 1);
        chk("R4", "empty", int'(empty), 1);
        wr(8'h77);                       // ignored while full
        chk_status("R4");
        wcommit();
        chk("R4", "empty_after_commit", int'(empty), 0);

        // R5: uncommitted read while full changes nothing, commit frees one
        cur_req = "R5";
        rd();
        chk("R5", "full_held", int'(full), 1);
        chk("R5", "free_held", int'(free_count), 0);
        rcommit();
        chk("R5", "full_cleared", int'(full), 0);
        chk("R5", "free_one", int'(free_count), 1);
        rd(); rcommit();
        chk("R5", "free_two", int'(free_count), 2);

        // R6: discard pending writes
        cur_req = "R6";
        wr(8'hE0); wr(8'hE1);
        chk("R6", "full_before", int'(full), 1);
        op(0, 0, 0, 1, 0, 0, 0);
        chk("R6", "free_restored", int'(free_count), 2);
        chk_status("R6");

        // R7: read remaining words, rewind, replay same sequence
        cur_req = "R7";
        for (int i = 2; i < D; i++) rd();
        chk("R7", "empty_after_reads", int'(empty), 1);
        cur_req = "R8";
        rd();                            // ignored while empty
        chk_status("R8");
        chk("R8", "free_held", int'(free_count), 2);
        cur_req = "R7";
        op(0, 0, 0, 0, 0, 0, 1);
        chk("R7", "empty_after_rewind", int'(empty), 0);
        chk("R7", "replay_head", int'(rd_data), 2);
        for (int i = 2; i < D; i++) rd();
        rcommit();
        chk("R7", "empty_final", int'(empty), 1);
        chk("R7", "free_final", int'(free_count), D);

        // R9: discard beats commit, same-cycle write dropped
        cur_req = "R9";
        wr(8'h11); wr(8'h12); wr(8'h13);
        op(1, 8'h14, 1, 1, 0, 0, 0);
        chk("R9", "free_wr_side", int'(free_count), D);
        chk("R9", "empty_wr_side", int'(empty), 1);
        wr(8'h21); wr(8'h22); wcommit();
        rd();
        op(0, 0, 0, 0, 1, 1, 1);         // read + commit + discard: rewind only
        chk("R9", "free_rd_side", int'(free_count), D - 2);
        chk("R9", "head_replayed", int'(rd_data), 8'h21);
        rd(); rd(); rcommit();
        chk_status("R9");

        // R10: order kept across wrap-around
        cur_req = "R10";
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < 11; i++) wr(8'(r * 16 + i));
            wcommit();
            for (int i = 0; i < 11; i++) rd();
            rcommit();
        end
        chk_status("R10");
        chk("R10", "scoreboard_drained", sb_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule